// File: doc/BRIEF.md
# Interrupt Cause Register Group

This block collects interrupt events from three sources (transmit, receive and miscellaneous) into three 32-bit cause registers. Each cause register has its own per-bit mask, adjusted through separate mask-set and mask-clear writes, and its own per-bit clear-mode register. A clear-mode bit at 1 makes that cause bit clear when the cause register is read. A clear-mode bit at 0 makes it clear only when a 1 is written to that position. Software can also force cause bits high by writing to a cause-set register. This lets a driver raise an interrupt itself, for example a handshake bit in the miscellaneous group.

A summary register has one sticky bit per group. A bit is set while its group has an unmasked pending cause bit, and the whole summary register clears when it is read. The summary register has its own 32-bit software mask. A single registered host interrupt line is high whenever any unmasked summary bit is set. Software reads the summary first, then the cause registers of the groups it flags, and acknowledges them in whichever mode each bit is set to.

The register bus is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr_i` is high. A read is presented one cycle after `bus_rd_i` and is marked by `bus_rvalid_o`. The event inputs are level/pulse vectors that are sampled on every clock. They have no handshake, because the block is always able to accept them.

Top module: `irq_cause_hub`

## Requirements
- R1: After reset every cause register and the summary register are 0, every group mask and the summary mask are all ones, every clear-mode register is 0, and `irq_o` is low.
- R2: An event bit that is high at a clock edge sets the matching cause bit after that edge, and the bit stays set after the event input drops.
- R3: Writing to a group's cause-set register (offset 1) sets exactly the cause bits written as 1.
- R4: Writing to a group's cause register (offset 0) clears the bits written as 1 whose clear-mode bit is 0. Bits whose clear-mode bit is 1 are not changed by this write.
- R5: Reading a group's cause register returns its value before the read, then clears the bits whose clear-mode bit is 1. Bits whose clear-mode bit is 0 are not changed by the read.
- R6: An event that arrives in the same cycle as a clear of that bit, by read or by write, leaves the bit set.
- R7: A mask-set write (offset 2) masks exactly the bits written as 1, and a mask-clear write (offset 3) unmasks exactly the bits written as 1. The mask reads back at offset 4, the masked cause (cause AND NOT mask) at offset 5, and the clear-mode register at offset 6 (read/write).
- R8: Summary bit 0 (transmit), bit 1 (receive) or bit 2 (miscellaneous) is set one cycle after its group has an unmasked pending bit, and higher summary bits are always 0. A set bit stays set until the summary register (address 24) is read. That read returns the old value and clears every bit whose group is no longer pending.
- R9: The summary mask (address 25, read/write, a 1 blocks a bit) gates the host line: `irq_o` equals, one cycle later, the OR of the summary bits that the mask does not block. Writing 0xFFFFFFF8 enables all three groups, and writing all ones blocks the line.
- R10: Read data appears on `bus_rdata_o` with `bus_rvalid_o` high in the cycle after `bus_rd_i`. Group g occupies word addresses 8*g to 8*g+6, and unmapped addresses read as 0.
- R11: Every bit is independent in both mask and clear mode. The miscellaneous handshake bit 27 can be left unmasked and in write-1-to-clear mode while all other bits of that group are masked and clear-on-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (never together with write) |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| tx_evt_i | input | 32 | Transmit group event bits |
| rx_evt_i | input | 32 | Receive group event bits |
| misc_evt_i | input | 32 | Miscellaneous group event bits |
| summary_o | output | 32 | Current summary cause value |
| irq_o | output | 1 | Registered host interrupt line |

## Verification
Each result has a fixed latency. A cause bit reflects an event or a register write one edge after the stimulus. A summary bit follows the group's pending state one edge later, so two edges after the event. `irq_o` follows the summary one edge after that, so three edges after the event. Read data lands one edge after the read strobe. A behavioural model in the bench applies the same edge-by-edge update order. It is compared with `irq_o`, `summary_o`, `bus_rvalid_o` and `bus_rdata_o` at every falling edge, so each output is checked exactly in the cycle it is due. Directed reads finish at the falling edge after their strobe. Checks on the host line wait two falling edges after the write that changes it.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // number of cause groups: 0 transmit, 1 receive, 2 miscellaneous
  localparam int unsigned NUM_GRP  = 3;
  // word offsets inside one group window of eight words
  localparam int unsigned OFS_W    = 3;
  // block index of the summary window (directly after the groups)
  localparam int unsigned SUMM_BLK = NUM_GRP;

  typedef enum logic [OFS_W-1:0] {
    OFS_CAUSE = 3'd0,
    OFS_SET   = 3'd1,
    OFS_MSET  = 3'd2,
    OFS_MCLR  = 3'd3,
    OFS_MASK  = 3'd4,
    OFS_PEND  = 3'd5,
    OFS_MODE  = 3'd6
  } grp_ofs_e;

  typedef enum logic [OFS_W-1:0] {
    SOFS_CAUSE = 3'd0,
    SOFS_MASK  = 3'd1
  } summ_ofs_e;

  // decoded per-group access strobes
  typedef struct packed {
    logic wr_cause;
    logic wr_set;
    logic wr_mset;
    logic wr_mclr;
    logic wr_mode;
    logic rd_cause;
  } grp_ctl_t;

endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group
  import irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  grp_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cause_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] mode_o,
  output logic [WIDTH-1:0] pend_o,
  output logic             active_o
);

  logic [WIDTH-1:0] cause_q, mask_q, mode_q;
  logic [WIDTH-1:0] clr_w1c, clr_cor, set_sw;
  logic [WIDTH-1:0] cause_d, mask_d, mode_d;

  // write-1-to-clear only touches bits in write-clear mode
  assign clr_w1c = ctl_i.wr_cause ? (wdata_i & ~mode_q) : '0;
  // a read of the cause register drops the clear-on-read bits
  assign clr_cor = ctl_i.rd_cause ? mode_q : '0;
  assign set_sw  = ctl_i.wr_set ? wdata_i : '0;

  // new events and forced bits are ORed after the clear: they win
  assign cause_d = (cause_q & ~(clr_w1c | clr_cor)) | evt_i | set_sw;

  always_comb begin
    mask_d = mask_q;
    if (ctl_i.wr_mset) begin
      mask_d = mask_q | wdata_i;
    end else if (ctl_i.wr_mclr) begin
      mask_d = mask_q & ~wdata_i;
    end
  end

  assign mode_d = ctl_i.wr_mode ? wdata_i : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      mode_q  <= mode_d;
    end
  end

  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign mode_o   = mode_q;
  assign pend_o   = cause_q & ~mask_q;
  assign active_o = |pend_o;

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_act_i,
  input  logic               rd_clr_i,
  input  logic               mask_wr_i,
  input  logic [WIDTH-1:0]   wdata_i,
  output logic [WIDTH-1:0]   summ_o,
  output logic [WIDTH-1:0]   mask_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] summ_q, summ_d;
  logic [WIDTH-1:0]   mask_q;
  logic               irq_q;

  // sticky until read; a still-pending source re-arms in the same edge
  assign summ_d = (rd_clr_i ? '0 : summ_q) | src_act_i;
  assign summ_o = WIDTH'(summ_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      summ_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      summ_q <= summ_d;
      if (mask_wr_i) begin
        mask_q <= wdata_i;
      end
      irq_q <= |(summ_o & ~mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/irq_cause_hub.sv
module irq_cause_hub
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [DATA_W-1:0] tx_evt_i,
  input  logic [DATA_W-1:0] rx_evt_i,
  input  logic [DATA_W-1:0] misc_evt_i,
  output logic [DATA_W-1:0] summary_o,
  output logic              irq_o
);

  localparam int unsigned BLK_W = ADDR_W - OFS_W;

  logic [BLK_W-1:0]  bus_blk;
  logic [OFS_W-1:0]  bus_ofs;
  logic [DATA_W-1:0] grp_evt   [NUM_GRP];
  logic [DATA_W-1:0] grp_cause [NUM_GRP];
  logic [DATA_W-1:0] grp_mask  [NUM_GRP];
  logic [DATA_W-1:0] grp_mode  [NUM_GRP];
  logic [DATA_W-1:0] grp_pend  [NUM_GRP];
  logic [NUM_GRP-1:0] grp_act;
  grp_ctl_t           grp_ctl  [NUM_GRP];

  logic              summ_hit, summ_rd_clr, smask_wr;
  logic [DATA_W-1:0] summ_val, smask_val;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign bus_blk = bus_addr_i[ADDR_W-1:OFS_W];
  assign bus_ofs = bus_addr_i[OFS_W-1:0];

  assign grp_evt[0] = tx_evt_i;
  assign grp_evt[1] = rx_evt_i;
  assign grp_evt[2] = misc_evt_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = (bus_blk == BLK_W'(g));

    assign grp_ctl[g].wr_cause = bus_wr_i & hit & (bus_ofs == OFS_CAUSE);
    assign grp_ctl[g].wr_set   = bus_wr_i & hit & (bus_ofs == OFS_SET);
    assign grp_ctl[g].wr_mset  = bus_wr_i & hit & (bus_ofs == OFS_MSET);
    assign grp_ctl[g].wr_mclr  = bus_wr_i & hit & (bus_ofs == OFS_MCLR);
    assign grp_ctl[g].wr_mode  = bus_wr_i & hit & (bus_ofs == OFS_MODE);
    assign grp_ctl[g].rd_cause = bus_rd_i & hit & (bus_ofs == OFS_CAUSE);

    irq_cause_group #(
      .WIDTH (DATA_W)
    ) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (grp_evt[g]),
      .ctl_i    (grp_ctl[g]),
      .wdata_i  (bus_wdata_i),
      .cause_o  (grp_cause[g]),
      .mask_o   (grp_mask[g]),
      .mode_o   (grp_mode[g]),
      .pend_o   (grp_pend[g]),
      .active_o (grp_act[g])
    );
  end

  assign summ_hit    = (bus_blk == BLK_W'(SUMM_BLK));
  assign summ_rd_clr = bus_rd_i & summ_hit & (bus_ofs == SOFS_CAUSE);
  assign smask_wr    = bus_wr_i & summ_hit & (bus_ofs == SOFS_MASK);

  irq_summary #(
    .WIDTH   (DATA_W),
    .NUM_SRC (NUM_GRP)
  ) u_summ (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_act_i (grp_act),
    .rd_clr_i  (summ_rd_clr),
    .mask_wr_i (smask_wr),
    .wdata_i   (bus_wdata_i),
    .summ_o    (summ_val),
    .mask_o    (smask_val),
    .irq_o     (irq_o)
  );

  // read multiplexer: values before any read side effect of this edge
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_blk == BLK_W'(g)) begin
        case (bus_ofs)
          OFS_CAUSE: rd_mux = grp_cause[g];
          OFS_MASK:  rd_mux = grp_mask[g];
          OFS_PEND:  rd_mux = grp_pend[g];
          OFS_MODE:  rd_mux = grp_mode[g];
          default:   rd_mux = '0;
        endcase
      end
    end
    if (summ_hit) begin
      case (bus_ofs)
        SOFS_CAUSE: rd_mux = summ_val;
        SOFS_MASK:  rd_mux = smask_val;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign summary_o    = summ_val;

endmodule

// File: rtl/irq_cause_hub_chk.sv
module irq_cause_hub_chk
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rvalid_o,
  input logic [DATA_W-1:0] summary_o,
  input logic [DATA_W-1:0] smask,
  input logic              irq_o
);

  logic summ_read;
  assign summ_read = bus_rd_i && (bus_addr_i == ADDR_W'(SUMM_BLK << OFS_W));

  // R9: an unblocked summary bit raises the line one cycle later
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(summary_o & ~smask)) |=> irq_o);

  // R9: with nothing unblocked the line is low one cycle later
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(summary_o & ~smask)) |=> !irq_o);

  // R10: read data is marked valid exactly one cycle after the strobe
  a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i |=> bus_rvalid_o);

  a_r10_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> !bus_rvalid_o);

  // R8: without a summary read no set summary bit is lost
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !summ_read |=> ((summary_o & $past(summary_o)) == $past(summary_o)));

  // R8: only the group bits of the summary can be set
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_o >> NUM_GRP) == '0);

endmodule

bind irq_cause_hub irq_cause_hub_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rvalid_o (bus_rvalid_o),
  .summary_o    (summary_o),
  .smask        (smask_val),
  .irq_o        (irq_o)
);

// File: tb/test_irq_cause_hub.sv
module test_irq_cause_hub;

  localparam int A_TX   = 0;
  localparam int A_RX   = 8;
  localparam int A_MISC = 16;
  localparam int A_SUMM = 24;
  localparam int A_SMSK = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] tx_evt = '0, rx_evt = '0, misc_evt = '0;
  logic [31:0] summary;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;

  always #2 clk = ~clk;

  irq_cause_hub i_irq_cause_hub (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_i     (bus_wr),
    .bus_rd_i     (bus_rd),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .bus_rvalid_o (bus_rvalid),
    .tx_evt_i     (tx_evt),
    .rx_evt_i     (rx_evt),
    .misc_evt_i   (misc_evt),
    .summary_o    (summary),
    .irq_o        (irq)
  );

  // behavioural reference model
  logic [31:0] m_cause [3];
  logic [31:0] m_mask  [3];
  logic [31:0] m_mode  [3];
  logic [31:0] m_summ, m_smask, m_rdata;
  logic        m_irq, m_rvalid;

  always @(posedge clk) begin
    logic [31:0] evs [3];
    logic [31:0] rv;
    int blk, ofs;
    evs[0] = tx_evt; evs[1] = rx_evt; evs[2] = misc_evt;
    blk = int'(bus_addr) / 8;
    ofs = int'(bus_addr) % 8;
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin
        m_cause[g] = 0; m_mask[g] = 32'hFFFF_FFFF; m_mode[g] = 0;
      end
      m_summ = 0; m_smask = 32'hFFFF_FFFF; m_rdata = 0;
      m_irq = 0; m_rvalid = 0;
    end else begin
      rv = 0;
      if (blk < 3) begin
        if (ofs == 0) rv = m_cause[blk];
        if (ofs == 4) rv = m_mask[blk];
        if (ofs == 5) rv = m_cause[blk] & ~m_mask[blk];
        if (ofs == 6) rv = m_mode[blk];
      end else if (blk == 3) begin
        if (ofs == 0) rv = m_summ;
        if (ofs == 1) rv = m_smask;
      end
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = rv;
      m_irq = (m_summ & ~m_smask) != 0;
      if (bus_rd && blk == 3 && ofs == 0) m_summ = 0;
      for (int g = 0; g < 3; g++)
        if ((m_cause[g] & ~m_mask[g]) != 0) m_summ[g] = 1'b1;
      if (bus_wr && blk == 3 && ofs == 1) m_smask = bus_wdata;
      for (int g = 0; g < 3; g++) begin
        if (bus_rd && blk == g && ofs == 0) m_cause[g] = m_cause[g] & ~m_mode[g];
        if (bus_wr && blk == g) begin
          if (ofs == 0) m_cause[g] = m_cause[g] & ~(bus_wdata & ~m_mode[g]);
          if (ofs == 1) m_cause[g] = m_cause[g] | bus_wdata;
          if (ofs == 2) m_mask[g] = m_mask[g] | bus_wdata;
          if (ofs == 3) m_mask[g] = m_mask[g] & ~bus_wdata;
          if (ofs == 6) m_mode[g] = bus_wdata;
        end
        m_cause[g] = m_cause[g] | evs[g];
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // compare outputs with the model at every falling edge
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check(irq === m_irq, "R9 irq line vs model", 32'(irq), 32'(m_irq));
      check(summary === m_summ, "R8 summary vs model", summary, m_summ);
      check(bus_rvalid === m_rvalid, "R10 rvalid vs model",
            32'(bus_rvalid), 32'(m_rvalid));
      if (m_rvalid)
        check(bus_rdata === m_rdata, "R10 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input int a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    check(d === e, tag, d, e);
  endtask

  task automatic pulse(input int g, input logic [31:0] v);
    @(negedge clk);
    if (g == 0) tx_evt = v; else if (g == 1) rx_evt = v; else misc_evt = v;
    @(negedge clk);
    tx_evt = 0; rx_evt = 0; misc_evt = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);

    // R1 reset values
    check(irq === 1'b0, "R1 irq low after reset", 32'(irq), 0);
    expect_rd(A_TX + 4, 32'hFFFF_FFFF, "R1 tx mask reset");
    expect_rd(A_SMSK, 32'hFFFF_FFFF, "R1 summary mask reset");
    expect_rd(A_MISC + 6, 0, "R1 misc clear-mode reset");
    expect_rd(A_RX, 0, "R1 rx cause reset");

    // R2 event capture, sticky; R5 read leaves write-clear bits
    pulse(0, 32'h5);
    expect_rd(A_TX, 32'h5, "R2 tx cause after event");
    expect_rd(A_TX, 32'h5, "R5 read keeps write-clear bits");

    // R7 mask clear and readback
    wr(A_TX + 3, 32'h1);
    expect_rd(A_TX + 4, 32'hFFFF_FFFE, "R7 mask after clear");
    expect_rd(A_TX + 5, 32'h1, "R7 masked cause");

    // R8 summary sets and re-arms while pending
    expect_rd(A_SUMM, 32'h1, "R8 summary tx bit");
    expect_rd(A_SUMM, 32'h1, "R8 summary re-armed");

    // R9 enabling the line
    check(irq === 1'b0, "R9 line blocked by mask", 32'(irq), 0);
    wr(A_SMSK, 32'hFFFF_FFF8);
    settle();
    check(irq === 1'b1, "R9 line raised", 32'(irq), 1);

    // R4 write-1-to-clear; R8 sticky then cleared by read
    wr(A_TX, 32'h1);
    expect_rd(A_TX, 32'h4, "R4 w1c cleared bit 0");
    expect_rd(A_SUMM, 32'h1, "R8 sticky after source cleared");
    expect_rd(A_SUMM, 32'h0, "R8 cleared by read");
    settle();
    check(irq === 1'b0, "R9 line dropped", 32'(irq), 0);

    // R5 clear-on-read on the low byte of rx
    wr(A_RX + 6, 32'hFF);
    pulse(1, 32'h103);
    expect_rd(A_RX, 32'h103, "R5 first read old value");
    expect_rd(A_RX, 32'h100, "R5 read cleared low byte");
    wr(A_RX, 32'h100);
    expect_rd(A_RX, 32'h0, "R4 w1c of bit 8");
    pulse(1, 32'h1);
    wr(A_RX, 32'h1);
    expect_rd(A_RX, 32'h1, "R4 write ignored for read-clear bit");
    expect_rd(A_RX, 32'h0, "R5 read cleared bit 0");

    // R3 forced cause
    wr(A_MISC + 1, 32'h0800_0000);
    expect_rd(A_MISC, 32'h0800_0000, "R3 forced handshake bit");

    // R11 handshake bit unmasked and write-clear, rest masked and read-clear
    wr(A_MISC + 3, 32'h0800_0000);
    wr(A_MISC + 6, 32'hF7FF_FFFF);
    expect_rd(A_MISC + 4, 32'hF7FF_FFFF, "R11 misc mask");
    pulse(2, 32'h1);
    expect_rd(A_MISC + 5, 32'h0800_0000, "R11 only handshake pending");
    expect_rd(A_MISC, 32'h0800_0001, "R11 misc cause");
    expect_rd(A_MISC, 32'h0800_0000, "R11 read cleared bit 0 only");
    check(irq === 1'b1, "R11 handshake raises line", 32'(irq), 1);
    expect_rd(A_SUMM, 32'h4, "R8 misc summary bit");
    wr(A_MISC, 32'h0800_0000);
    expect_rd(A_MISC, 32'h0, "R11 handshake w1c");
    expect_rd(A_SUMM, 32'h4, "R8 misc sticky");
    expect_rd(A_SUMM, 32'h0, "R8 misc cleared");

    // R6 event beats clear-on-read in the same cycle
    @(negedge clk);
    rx_evt = 32'h1; bus_rd = 1'b1; bus_addr = 6'(A_RX);
    @(negedge clk);
    rx_evt = 0; bus_rd = 1'b0;
    check(bus_rdata === 0, "R6 read shows old value", bus_rdata, 0);
    expect_rd(A_RX, 32'h1, "R6 event kept over read clear");

    // R6 event beats write-1-to-clear in the same cycle
    @(negedge clk);
    tx_evt = 32'h4; bus_wr = 1'b1; bus_addr = 6'(A_TX); bus_wdata = 32'h4;
    @(negedge clk);
    tx_evt = 0; bus_wr = 1'b0;
    expect_rd(A_TX, 32'h4, "R6 event kept over w1c");
    wr(A_TX, 32'h4);
    expect_rd(A_TX, 32'h0, "R4 w1c bit 2");

    // R10 unmapped addresses
    expect_rd(7, 32'h0, "R10 unmapped group offset");
    expect_rd(30, 32'h0, "R10 unmapped summary offset");

    // R7 mask set; R9 blocking the line again
    wr(A_MISC + 1, 32'h0800_0000);
    settle();
    check(irq === 1'b1, "R9 line on before block", 32'(irq), 1);
    wr(A_SMSK, 32'hFFFF_FFFF);
    settle();
    check(irq === 1'b0, "R9 line blocked", 32'(irq), 0);
    expect_rd(A_SMSK, 32'hFFFF_FFFF, "R9 summary mask readback");
    wr(A_MISC + 2, 32'h0800_0000);
    expect_rd(A_MISC + 4, 32'hFFFF_FFFF, "R7 mask after set");
    expect_rd(A_MISC + 5, 32'h0, "R7 masked cause after set");

    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule